// File: doc/BRIEF.md
# Interrupt Controller Command Port

This block is the byte-wide programming port of one eight-line interrupt controller. A host writes and reads it through a single address bit and separate read and write strobes. A second register space, picked by a select input, holds the per-line trigger-mode bits. The port runs the multi-word initialization sequence and decodes the operational command words. It then holds the control state that the request and priority logic of the controller consume: the line mask, the vector base, the rotating priority base, the auto end-of-interrupt and nested-mode flags, and the special-mask flag. It also issues one-cycle strobes that clear in-service and request bits.

The priority search is not part of this block. The highest-priority in-service line, and the result a poll would return, arrive on inputs from the neighbouring priority logic. The request and in-service registers arrive on inputs only so that they can be read back. All writes take effect at the clock edge on which the write strobe is sampled. The data output is combinational from the current state and inputs.

Top module: `pic_cmd_port`

## Requirements
- R1: After a synchronous active-low reset, the following all read zero: the mask, the vector base, the priority base, every mode flag and the trigger-mode register. A write to address 1 then loads the mask, and a read at address 0 returns the request input.
- R2: An address-0 write with data bit 4 set starts initialization. On the next cycle the mask, vector base, priority base, auto-EOI, nested, rotate-on-auto-EOI, special-mask, read-select and poll state are all zero. In that same cycle init_clear_o is high for exactly one cycle.
- R3: Address-1 writes follow the init step. In the idle step they load the mask. The first word after init stores the data with bits 2:0 forced to zero as the vector base. The second word is consumed. A third word is expected only if bit 0 of the init word was 1; it sets nested mode from bit 4 and auto-EOI from bit 1. After the last word, writes load the mask again.
- R4: An address-0 write with bit 4 clear and bit 3 set is a control word. Bit 2 arms poll. When bit 1 is 1, bit 0 sets read-select. When bit 6 is 1, bit 5 sets the special mask; when bit 6 is 0, the special mask is unchanged.
- R5: An address-0 write with bits 4 and 3 clear is a command whose code is bits 7:5. Code 0 clears rotate-on-auto-EOI and code 4 sets it.
- R6: Codes 1 and 5 pulse isr_clr_o one-hot at the index on top_isr_idx, in the cycle after the write, when top_isr_vld is 1. Code 5 also sets the priority base to that index plus 1, modulo 8. With top_isr_vld at 0, neither code has any effect.
- R7: Code 3 pulses isr_clr_o at the index in data bits 2:0. Code 6 sets the priority base to bits 2:0 plus 1, modulo 8. Code 7 does both. Code 2 changes nothing.
- R8: With poll not armed, a read at address 0 returns isr_in if read-select is 1 and irr_in if it is 0. A read at address 1 returns the mask.
- R9: While poll is armed, the read data is {5'b0, poll_idx} when poll_vld is 1 and 8'h07 when it is 0. A read disarms poll. A read with poll_vld at 1 pulses isr_clr_o and irr_clr_o at poll_idx in the next cycle.
- R10: A write with tm_sel high stores the data ANDed with 8'hF8 on a master (IS_MASTER=1) or with 8'hDE on a slave. A read with tm_sel high returns that register. Such a write does not touch the mask.
- R11: isr_clr_o, irr_clr_o and init_clear_o each last a single cycle per triggering access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| a0 | input | 1 | Address bit 0 of the command space |
| tm_sel | input | 1 | Selects the trigger-mode register space |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, combinational |
| irr_in | input | 8 | Request register, for readback |
| isr_in | input | 8 | In-service register, for readback |
| top_isr_vld | input | 1 | Some line is in service |
| top_isr_idx | input | 3 | Highest-priority in-service line |
| poll_vld | input | 1 | A line would be granted |
| poll_idx | input | 3 | Line that would be granted |
| mask_o | output | 8 | Line mask |
| vec_base_o | output | 8 | Vector base, bits 2:0 zero |
| rot_base_o | output | 3 | Line that currently has top priority |
| auto_eoi_o | output | 1 | Auto end-of-interrupt mode |
| nested_o | output | 1 | Special nested mode |
| rot_aeoi_o | output | 1 | Rotate on auto end-of-interrupt |
| special_mask_o | output | 1 | Special mask mode |
| trig_mode_o | output | 8 | Per-line level-trigger bits |
| isr_clr_o | output | 8 | One-cycle in-service clear strobe |
| irr_clr_o | output | 8 | One-cycle request clear strobe |
| init_clear_o | output | 1 | One-cycle request/in-service wipe and output drop |

## Verification
The command decoder is driven with every code from 0 to 7. The end-of-interrupt codes are tried with the top in-service input both valid and invalid, which separates the non-specific clear from the specific one and the rotating forms from the plain ones. Two initializations are run, one that asks for the optional fourth word and one that does not. This shows whether the step machine branches on the saved flag, and whether a write after the sequence lands in the mask. Poll reads are done with and without a pending line, which separates the 07 fallback from a real grant and shows the disarm. The trigger-mode register is written with all ones on both a master and a slave instance, which separates the two fixed masks.

// File: rtl/pic_cmd_pkg.sv
// Package: shared widths, the init step encoding and the command codes of
// the controller command port. Assumes an eight-line controller.
package pic_cmd_pkg;
    localparam int LINES = 8;
    localparam int IDX_W = $clog2(LINES);
    localparam int DW    = LINES;

    // Bit positions in an address-0 write
    localparam int B_INIT    = 4;
    localparam int B_CTRL    = 3;
    localparam int B_POLL    = 2;
    localparam int B_SEL_EN  = 1;
    localparam int B_SEL_VAL = 0;
    localparam int B_SMM_EN  = 6;
    localparam int B_SMM_VAL = 5;
    localparam int B_NEED4   = 0;
    // Bit positions in the optional fourth init word
    localparam int B_NESTED  = 4;
    localparam int B_AEOI    = 1;

    typedef enum logic [1:0] {
        STEP_IDLE    = 2'd0,
        STEP_BASE    = 2'd1,
        STEP_CASCADE = 2'd2,
        STEP_MODE    = 2'd3
    } init_step_e;

    typedef enum logic [2:0] {
        OP_RAEOI_OFF  = 3'd0,
        OP_EOI_TOP    = 3'd1,
        OP_NOP        = 3'd2,
        OP_EOI_AT     = 3'd3,
        OP_RAEOI_ON   = 3'd4,
        OP_EOI_TOP_RT = 3'd5,
        OP_SET_BASE   = 3'd6,
        OP_EOI_AT_RT  = 3'd7
    } cmd_op_e;
endpackage

// File: rtl/pic_cmd_init_seq.sv
// Module: initialization step machine. Owns the mask, vector base, nested
// and auto-EOI flags. Assumes wr_a0/wr_a1 are already qualified for the
// command space and are never high together.
module pic_cmd_init_seq
    import pic_cmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_a0,
    input  logic          wr_a1,
    input  logic [DW-1:0] din,
    output logic          init_start,
    output logic          init_pulse_o,
    output logic [DW-1:0] mask_o,
    output logic [DW-1:0] vec_base_o,
    output logic          nested_o,
    output logic          aeoi_o,
    output init_step_e    step_o
);
    localparam logic [DW-1:0] VEC_KEEP = ~DW'((1 << IDX_W) - 1);

    logic need4_q;

    // Detect an init word
    always_comb init_start = wr_a0 & din[B_INIT];

    // Step machine and the registers loaded by init words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_o       <= STEP_IDLE;
            need4_q      <= 1'b0;
            mask_o       <= '0;
            vec_base_o   <= '0;
            nested_o     <= 1'b0;
            aeoi_o       <= 1'b0;
            init_pulse_o <= 1'b0;
        end else begin
            init_pulse_o <= init_start;
            if (init_start) begin
                step_o     <= STEP_BASE;
                need4_q    <= din[B_NEED4];
                mask_o     <= '0;
                vec_base_o <= '0;
                nested_o   <= 1'b0;
                aeoi_o     <= 1'b0;
            end else if (wr_a1) begin
                unique case (step_o)
                    STEP_IDLE: mask_o <= din;
                    STEP_BASE: begin
                        vec_base_o <= din & VEC_KEEP;
                        step_o     <= STEP_CASCADE;
                    end
                    STEP_CASCADE: step_o <= need4_q ? STEP_MODE : STEP_IDLE;
                    STEP_MODE: begin
                        nested_o <= din[B_NESTED];
                        aeoi_o   <= din[B_AEOI];
                        step_o   <= STEP_IDLE;
                    end
                    default: step_o <= STEP_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/pic_cmd_decode.sv
// Module: control-word and command decoder. Owns priority base, read-select,
// poll, special mask and rotate-on-auto-EOI, and drives the clear strobes.
// Assumes top_isr_* and poll_* come from the neighbouring priority search.
module pic_cmd_decode
    import pic_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_a0,
    input  logic             init_start,
    input  logic [DW-1:0]    din,
    input  logic             top_isr_vld,
    input  logic [IDX_W-1:0] top_isr_idx,
    input  logic             poll_take,
    input  logic             poll_vld,
    input  logic [IDX_W-1:0] poll_idx,
    output logic [IDX_W-1:0] rot_base_o,
    output logic             rot_aeoi_o,
    output logic             read_sel_o,
    output logic             poll_armed_o,
    output logic             special_mask_o,
    output logic [DW-1:0]    isr_clr_o,
    output logic [DW-1:0]    irr_clr_o
);
    logic             is_ctrl, is_cmd;
    cmd_op_e          op;
    logic             clr_go, base_go;
    logic [IDX_W-1:0] clr_idx, base_idx;

    // Classify an address-0 write that is not an init word
    always_comb begin
        is_ctrl = wr_a0 & ~din[B_INIT] &  din[B_CTRL];
        is_cmd  = wr_a0 & ~din[B_INIT] & ~din[B_CTRL];
        op      = cmd_op_e'(din[DW-1 -: 3]);
    end

    // Work out which in-service bit a command clears and any new base
    always_comb begin
        clr_go   = 1'b0;
        base_go  = 1'b0;
        clr_idx  = din[IDX_W-1:0];
        base_idx = din[IDX_W-1:0];
        unique case (op)
            OP_EOI_TOP: begin
                clr_go  = top_isr_vld;
                clr_idx = top_isr_idx;
            end
            OP_EOI_TOP_RT: begin
                clr_go   = top_isr_vld;
                base_go  = top_isr_vld;
                clr_idx  = top_isr_idx;
                base_idx = top_isr_idx;
            end
            OP_EOI_AT:    clr_go = 1'b1;
            OP_SET_BASE:  base_go = 1'b1;
            OP_EOI_AT_RT: begin
                clr_go  = 1'b1;
                base_go = 1'b1;
            end
            default: begin
                clr_go  = 1'b0;
                base_go = 1'b0;
            end
        endcase
    end

    // Mode registers and one-cycle clear strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rot_base_o     <= '0;
            rot_aeoi_o     <= 1'b0;
            read_sel_o     <= 1'b0;
            poll_armed_o   <= 1'b0;
            special_mask_o <= 1'b0;
            isr_clr_o      <= '0;
            irr_clr_o      <= '0;
        end else if (init_start) begin
            rot_base_o     <= '0;
            rot_aeoi_o     <= 1'b0;
            read_sel_o     <= 1'b0;
            poll_armed_o   <= 1'b0;
            special_mask_o <= 1'b0;
            isr_clr_o      <= '0;
            irr_clr_o      <= '0;
        end else begin
            isr_clr_o <= '0;
            irr_clr_o <= '0;
            if (poll_take) begin
                poll_armed_o <= 1'b0;
                if (poll_vld) begin
                    isr_clr_o <= DW'(1) << poll_idx;
                    irr_clr_o <= DW'(1) << poll_idx;
                end
            end
            if (is_ctrl) begin
                if (din[B_POLL])   poll_armed_o   <= 1'b1;
                if (din[B_SEL_EN]) read_sel_o     <= din[B_SEL_VAL];
                if (din[B_SMM_EN]) special_mask_o <= din[B_SMM_VAL];
            end
            if (is_cmd) begin
                if (op == OP_RAEOI_OFF) rot_aeoi_o <= 1'b0;
                if (op == OP_RAEOI_ON)  rot_aeoi_o <= 1'b1;
                if (clr_go)  isr_clr_o  <= DW'(1) << clr_idx;
                if (base_go) rot_base_o <= base_idx + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/pic_cmd_trig.sv
// Module: trigger-mode register. The writable bits are fixed by the role
// of the controller, picked at elaboration time.
module pic_cmd_trig
    import pic_cmd_pkg::*;
#(
    parameter bit IS_MASTER = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] trig_o
);
    logic [DW-1:0] keep;

    // Choose the writable-bit pattern for this role
    generate
        if (IS_MASTER) begin : g_master
            assign keep = 8'hF8;
        end else begin : g_slave
            assign keep = 8'hDE;
        end
    endgenerate

    // Store the masked write data
    always_ff @(posedge clk) begin
        if (!rst_n)  trig_o <= '0;
        else if (wr) trig_o <= din & keep;
    end
endmodule

// File: rtl/pic_cmd_readback.sv
// Module: combinational read-data multiplexer. Assumes the poll result
// takes precedence over every command-space register.
module pic_cmd_readback
    import pic_cmd_pkg::*;
(
    input  logic             tm_sel,
    input  logic             a0,
    input  logic             poll_armed,
    input  logic             poll_vld,
    input  logic [IDX_W-1:0] poll_idx,
    input  logic             read_sel,
    input  logic [DW-1:0]    irr_in,
    input  logic [DW-1:0]    isr_in,
    input  logic [DW-1:0]    mask,
    input  logic [DW-1:0]    trig,
    output logic [DW-1:0]    dout
);
    localparam logic [DW-1:0] NO_GRANT = DW'(LINES - 1);

    // Select the read data
    always_comb begin
        if (tm_sel)          dout = trig;
        else if (poll_armed) dout = poll_vld ? DW'(poll_idx) : NO_GRANT;
        else if (a0)         dout = mask;
        else if (read_sel)   dout = isr_in;
        else                 dout = irr_in;
    end
endmodule

// File: rtl/pic_cmd_port.sv
// Module: command port of one interrupt controller. Qualifies the strobes
// and wires the init machine, command decoder, trigger register and read
// mux together. Assumes wr_en and rd_en are not high in the same cycle.
module pic_cmd_port
    import pic_cmd_pkg::*;
#(
    parameter bit IS_MASTER = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             a0,
    input  logic             tm_sel,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout,
    input  logic [DW-1:0]    irr_in,
    input  logic [DW-1:0]    isr_in,
    input  logic             top_isr_vld,
    input  logic [IDX_W-1:0] top_isr_idx,
    input  logic             poll_vld,
    input  logic [IDX_W-1:0] poll_idx,
    output logic [DW-1:0]    mask_o,
    output logic [DW-1:0]    vec_base_o,
    output logic [IDX_W-1:0] rot_base_o,
    output logic             auto_eoi_o,
    output logic             nested_o,
    output logic             rot_aeoi_o,
    output logic             special_mask_o,
    output logic [DW-1:0]    trig_mode_o,
    output logic [DW-1:0]    isr_clr_o,
    output logic [DW-1:0]    irr_clr_o,
    output logic             init_clear_o
);
    logic       wr_a0, wr_a1, wr_tm, poll_take;
    logic       init_start, read_sel, poll_armed;
    init_step_e step;

    // Qualify the access strobes per register space
    always_comb begin
        wr_a0     = wr_en & ~tm_sel & ~a0;
        wr_a1     = wr_en & ~tm_sel &  a0;
        wr_tm     = wr_en &  tm_sel;
        poll_take = rd_en & ~tm_sel & poll_armed;
    end

    pic_cmd_init_seq u_init (
        .clk(clk), .rst_n(rst_n), .wr_a0(wr_a0), .wr_a1(wr_a1), .din(din),
        .init_start(init_start), .init_pulse_o(init_clear_o),
        .mask_o(mask_o), .vec_base_o(vec_base_o), .nested_o(nested_o),
        .aeoi_o(auto_eoi_o), .step_o(step)
    );

    pic_cmd_decode u_dec (
        .clk(clk), .rst_n(rst_n), .wr_a0(wr_a0), .init_start(init_start),
        .din(din), .top_isr_vld(top_isr_vld), .top_isr_idx(top_isr_idx),
        .poll_take(poll_take), .poll_vld(poll_vld), .poll_idx(poll_idx),
        .rot_base_o(rot_base_o), .rot_aeoi_o(rot_aeoi_o),
        .read_sel_o(read_sel), .poll_armed_o(poll_armed),
        .special_mask_o(special_mask_o), .isr_clr_o(isr_clr_o),
        .irr_clr_o(irr_clr_o)
    );

    pic_cmd_trig #(.IS_MASTER(IS_MASTER)) u_trig (
        .clk(clk), .rst_n(rst_n), .wr(wr_tm), .din(din), .trig_o(trig_mode_o)
    );

    pic_cmd_readback u_rb (
        .tm_sel(tm_sel), .a0(a0), .poll_armed(poll_armed), .poll_vld(poll_vld),
        .poll_idx(poll_idx), .read_sel(read_sel), .irr_in(irr_in),
        .isr_in(isr_in), .mask(mask_o), .trig(trig_mode_o), .dout(dout)
    );
endmodule

// File: rtl/pic_cmd_port_chk.sv
// Module: property checker bound to the command port. Observes ports plus
// the init step and poll state.
module pic_cmd_port_chk
    import pic_cmd_pkg::*;
#(
    parameter bit IS_MASTER = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          tm_sel,
    input logic          a0,
    input logic [DW-1:0] din,
    input logic [DW-1:0] mask_o,
    input logic [DW-1:0] vec_base_o,
    input logic [DW-1:0] trig_mode_o,
    input logic [DW-1:0] isr_clr_o,
    input logic [DW-1:0] irr_clr_o,
    input logic          init_clear_o,
    input logic          poll_armed,
    input init_step_e    step
);
    localparam logic [DW-1:0] KEEP = IS_MASTER ? 8'hF8 : 8'hDE;

    // R6
    isr_clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(isr_clr_o));

    // R9
    irr_clr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irr_clr_o != '0) |-> (irr_clr_o == isr_clr_o));

    // R2
    init_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_clear_o |-> (mask_o == '0 && vec_base_o == '0 && isr_clr_o == '0));

    // R3
    vec_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_base_o[IDX_W-1:0] == '0);

    // R3
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !tm_sel && a0 && step == STEP_IDLE) |=> (mask_o == $past(din)));

    // R9
    poll_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !tm_sel && poll_armed) |=> !poll_armed);

    // R10
    trig_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_mode_o & ~KEEP) == '0);
endmodule

bind pic_cmd_port pic_cmd_port_chk #(.IS_MASTER(IS_MASTER)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .tm_sel(tm_sel),
    .a0(a0), .din(din), .mask_o(mask_o), .vec_base_o(vec_base_o),
    .trig_mode_o(trig_mode_o), .isr_clr_o(isr_clr_o), .irr_clr_o(irr_clr_o),
    .init_clear_o(init_clear_o), .poll_armed(poll_armed), .step(step)
);

// File: tb/pic_cmd_port_bench.sv
module pic_cmd_port_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, a0 = 1'b0, tm_sel = 1'b0;
    logic [7:0] din = '0, irr_in = 8'h5A, isr_in = 8'hC3;
    logic       top_isr_vld = 1'b0, poll_vld = 1'b0;
    logic [2:0] top_isr_idx = '0, poll_idx = '0;
    logic [7:0] dout, mask_o, vec_base_o, trig_mode_o, isr_clr_o, irr_clr_o;
    logic [2:0] rot_base_o;
    logic       auto_eoi_o, nested_o, rot_aeoi_o, special_mask_o, init_clear_o;
    logic [7:0] s_dout, s_mask, s_vec, s_trig, s_iclr, s_rclr;
    logic [2:0] s_rot;
    logic       s_aeoi, s_nest, s_raeoi, s_smm, s_init;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_cmd_port #(.IS_MASTER(1'b1)) u_pic_cmd_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .a0(a0),
        .tm_sel(tm_sel), .din(din), .dout(dout), .irr_in(irr_in), .isr_in(isr_in),
        .top_isr_vld(top_isr_vld), .top_isr_idx(top_isr_idx),
        .poll_vld(poll_vld), .poll_idx(poll_idx), .mask_o(mask_o),
        .vec_base_o(vec_base_o), .rot_base_o(rot_base_o), .auto_eoi_o(auto_eoi_o),
        .nested_o(nested_o), .rot_aeoi_o(rot_aeoi_o),
        .special_mask_o(special_mask_o), .trig_mode_o(trig_mode_o),
        .isr_clr_o(isr_clr_o), .irr_clr_o(irr_clr_o), .init_clear_o(init_clear_o)
    );

    pic_cmd_port #(.IS_MASTER(1'b0)) u_pic_cmd_port_slv (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .a0(a0),
        .tm_sel(tm_sel), .din(din), .dout(s_dout), .irr_in(irr_in), .isr_in(isr_in),
        .top_isr_vld(top_isr_vld), .top_isr_idx(top_isr_idx),
        .poll_vld(poll_vld), .poll_idx(poll_idx), .mask_o(s_mask),
        .vec_base_o(s_vec), .rot_base_o(s_rot), .auto_eoi_o(s_aeoi),
        .nested_o(s_nest), .rot_aeoi_o(s_raeoi), .special_mask_o(s_smm),
        .trig_mode_o(s_trig), .isr_clr_o(s_iclr), .irr_clr_o(s_rclr),
        .init_clear_o(s_init)
    );

    // Vector: a0[31] din[30:23] top_vld[22] top_idx[21:19]
    //         exp_clr[18:11] exp_rot[10:8] exp_mask[7:0]
    localparam int NV = 10;
    localparam logic [31:0] VEC [NV] = '{
        {1'b1, 8'hA5, 1'b0, 3'd0, 8'h00, 3'd0, 8'hA5},  // R3 mask load
        {1'b0, 8'h20, 1'b1, 3'd3, 8'h08, 3'd0, 8'hA5},  // R6 code 1
        {1'b0, 8'hA0, 1'b1, 3'd6, 8'h40, 3'd7, 8'hA5},  // R6 code 5
        {1'b0, 8'hA0, 1'b0, 3'd2, 8'h00, 3'd7, 8'hA5},  // R6 code 5, none
        {1'b0, 8'h65, 1'b0, 3'd0, 8'h20, 3'd7, 8'hA5},  // R7 code 3
        {1'b0, 8'hC2, 1'b0, 3'd0, 8'h00, 3'd3, 8'hA5},  // R7 code 6
        {1'b0, 8'hE7, 1'b0, 3'd0, 8'h80, 3'd0, 8'hA5},  // R7 code 7 wraps
        {1'b0, 8'h44, 1'b1, 3'd1, 8'h00, 3'd0, 8'hA5},  // R7 code 2
        {1'b0, 8'h20, 1'b1, 3'd0, 8'h01, 3'd0, 8'hA5},  // R6 code 1, idx 0
        {1'b1, 8'h3C, 1'b0, 3'd0, 8'h00, 3'd0, 8'h3C}   // R3 mask load
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge with outputs updated
    task automatic do_wr(input logic addr, input logic tm, input logic [7:0] d);
        wr_en = 1'b1; a0 = addr; tm_sel = tm; din = d;
        @(negedge clk);
        wr_en = 1'b0; tm_sel = 1'b0;
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 mask", mask_o, 8'h00);
        chk("R1 vec", vec_base_o, 8'h00);
        chk("R1 rot", rot_base_o, 3'd0);
        chk("R1 flags", {auto_eoi_o, nested_o, rot_aeoi_o, special_mask_o, init_clear_o}, 5'b0);
        chk("R1 trig", trig_mode_o, 8'h00);
        a0 = 1'b0; #1;
        chk("R1 read irr", dout, 8'h5A);

        // Table walk: commands and mask loads
        for (int i = 0; i < NV; i++) begin
            top_isr_vld = VEC[i][22];
            top_isr_idx = VEC[i][21:19];
            do_wr(VEC[i][31], 1'b0, VEC[i][30:23]);
            chk($sformatf("R6/R7 clr v%0d", i), isr_clr_o, VEC[i][18:11]);
            chk($sformatf("R6/R7 rot v%0d", i), rot_base_o, VEC[i][10:8]);
            chk($sformatf("R3 mask v%0d", i), mask_o, VEC[i][7:0]);
        end
        top_isr_vld = 1'b0;
        @(negedge clk);
        chk("R11 clr single", isr_clr_o, 8'h00);

        // R8 readback of mask
        a0 = 1'b1; #1;
        chk("R8 read mask", dout, 8'h3C);

        // R5 rotate-on-auto-EOI
        do_wr(1'b0, 1'b0, 8'h80);
        chk("R5 set", rot_aeoi_o, 1'b1);
        do_wr(1'b0, 1'b0, 8'h00);
        chk("R5 clear", rot_aeoi_o, 1'b0);
        do_wr(1'b0, 1'b0, 8'h80);
        do_wr(1'b0, 1'b0, 8'hC4);   // base to 5 before init
        chk("R7 base 5", rot_base_o, 3'd5);

        // R2/R3 init with fourth word
        do_wr(1'b0, 1'b0, 8'h11);
        chk("R2 pulse", init_clear_o, 1'b1);
        chk("R2 mask", mask_o, 8'h00);
        chk("R2 rot", rot_base_o, 3'd0);
        chk("R2 raeoi", rot_aeoi_o, 1'b0);
        @(negedge clk);
        chk("R11 init single", init_clear_o, 1'b0);
        do_wr(1'b1, 1'b0, 8'h4F);
        chk("R3 vec", vec_base_o, 8'h48);
        do_wr(1'b1, 1'b0, 8'hFF);
        chk("R3 cascade no mask", mask_o, 8'h00);
        do_wr(1'b1, 1'b0, 8'h12);
        chk("R3 nested", nested_o, 1'b1);
        chk("R3 aeoi", auto_eoi_o, 1'b1);
        chk("R3 mode no mask", mask_o, 8'h00);
        do_wr(1'b1, 1'b0, 8'h77);
        chk("R3 mask after 4", mask_o, 8'h77);

        // R2/R3 init without fourth word
        do_wr(1'b0, 1'b0, 8'h10);
        chk("R2 nested clr", nested_o, 1'b0);
        chk("R2 aeoi clr", auto_eoi_o, 1'b0);
        chk("R2 vec clr", vec_base_o, 8'h00);
        do_wr(1'b1, 1'b0, 8'h20);
        chk("R3 vec2", vec_base_o, 8'h20);
        do_wr(1'b1, 1'b0, 8'h55);
        do_wr(1'b1, 1'b0, 8'h99);
        chk("R3 mask after 3", mask_o, 8'h99);
        chk("R3 nested kept", nested_o, 1'b0);

        // R4/R8 read-select and special mask
        do_wr(1'b0, 1'b0, 8'h0B);
        a0 = 1'b0; #1;
        chk("R8 read isr", dout, 8'hC3);
        @(negedge clk);
        do_wr(1'b0, 1'b0, 8'h09);   // bit1 clear: select unchanged
        a0 = 1'b0; #1;
        chk("R4 sel held", dout, 8'hC3);
        @(negedge clk);
        do_wr(1'b0, 1'b0, 8'h0A);
        a0 = 1'b0; #1;
        chk("R4 sel irr", dout, 8'h5A);
        @(negedge clk);
        do_wr(1'b0, 1'b0, 8'h68);
        chk("R4 smm set", special_mask_o, 1'b1);
        do_wr(1'b0, 1'b0, 8'h28);
        chk("R4 smm gated", special_mask_o, 1'b1);
        do_wr(1'b0, 1'b0, 8'h48);
        chk("R4 smm clr", special_mask_o, 1'b0);

        // R9 poll with a pending line
        do_wr(1'b0, 1'b0, 8'h0C);
        poll_vld = 1'b1; poll_idx = 3'd5;
        rd_en = 1'b1; a0 = 1'b1; #1;
        chk("R9 poll data", dout, 8'h05);
        @(negedge clk);
        rd_en = 1'b0;
        chk("R9 isr clr", isr_clr_o, 8'h20);
        chk("R9 irr clr", irr_clr_o, 8'h20);
        #1;
        chk("R9 disarmed", dout, 8'h99);
        @(negedge clk);
        chk("R11 irr single", irr_clr_o, 8'h00);

        // R9 poll with nothing pending
        do_wr(1'b0, 1'b0, 8'h0C);
        poll_vld = 1'b0;
        rd_en = 1'b1; a0 = 1'b0; #1;
        chk("R9 poll none", dout, 8'h07);
        @(negedge clk);
        rd_en = 1'b0;
        chk("R9 none no clr", isr_clr_o, 8'h00);
        #1;
        chk("R9 none disarmed", dout, 8'h5A);
        @(negedge clk);

        // R10 trigger-mode register, master and slave
        do_wr(1'b0, 1'b1, 8'hFF);
        chk("R10 master", trig_mode_o, 8'hF8);
        chk("R10 slave", s_trig, 8'hDE);
        chk("R10 mask kept", mask_o, 8'h99);
        tm_sel = 1'b1; rd_en = 1'b1; #1;
        chk("R10 readback", dout, 8'hF8);
        @(negedge clk);
        rd_en = 1'b0; tm_sel = 1'b0;

        // R1 reset again mid-operation
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 re-reset mask", mask_o, 8'h00);
        chk("R1 re-reset trig", trig_mode_o, 8'h00);
        do_wr(1'b1, 1'b0, 8'h81);
        chk("R1 step idle", mask_o, 8'h81);

        finish_run();
    end
endmodule